// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps a 1024-row DRAM alive. A free-running interval timer adds one owed refresh every `TICK_CYCLES` clocks. The default is 3125 clocks: one sixteen-millisecond retention window split over 1024 rows, at a 200 MHz controller clock. The owed refreshes build up in a saturating pending counter. While any are owed and no refresh is in flight, the block requests the memory bus from the access arbiter. When the counter is full, the block raises an urgent flag so the arbiter can give refresh priority over ordinary traffic.

When the arbiter grants the bus, the block drives the row strobe, both byte column strobes and the write enable through one refresh cycle. In the default mode both column strobes fall before the row strobe, so the device takes the row to refresh from its own internal counter and no address is driven. With `RAS_ONLY` set, the column strobes stay high. The block then drives a 10-bit row number of its own onto the address bus and advances it after every completed refresh.

Each completed cycle removes one entry from the pending count. While no refresh cycle is running, every strobe rests high and the address bus is released.

Top module: `refresh_sched`

## Requirements
- R1: While reset is held and right after it, pending count is 0, request, urgent, busy and done are low, all four strobes are high, address enable is low and the address is 0.
- R2: The pending count rises by one at the clock edge `TICK_CYCLES` clocks after reset release, and again every `TICK_CYCLES` clocks after that.
- R3: The pending count saturates at `MAX_PEND`, and further intervals are lost. The urgent output is high exactly while the count equals `MAX_PEND`.
- R4: The request output is high when the count is non-zero and no refresh is running. A grant that arrives while the request is low starts nothing.
- R5: In the default mode, the edge that takes a grant drops both column strobes with the row strobe high, for `SETUP_CYC` cycles. Then the row strobe is low, with the column strobes still low, for `RAS_LOW_CYC` cycles. Then all strobes are high for `PRE_CYC` cycles. The address enable stays low throughout.
- R6: When precharge ends, the block returns to idle. Done is high for exactly one cycle and the pending count falls by one on that same edge.
- R7: A completion and an interval on the same edge leave the pending count unchanged.
- R8: In `RAS_ONLY` mode, both column strobes stay high for the whole cycle. The address enable is high from the grant edge until the row strobe rises. The row strobe is low for `RAS_LOW_CYC` cycles.
- R9: In `RAS_ONLY` mode, the driven row is 0 for the first refresh after reset and rises by one per completed refresh. It wraps from 1023 to 0.
- R10: The write enable stays high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gnt_i | input | 1 | Bus grant from the access arbiter |
| req_o | output | 1 | Refresh owed and sequencer idle |
| urgent_o | output | 1 | Pending count at its limit |
| pend_o | output | $clog2(MAX_PEND+1) | Number of owed refreshes |
| busy_o | output | 1 | Refresh cycle in progress |
| done_o | output | 1 | One-cycle pulse when a refresh completes |
| ras_n_o | output | 1 | Row strobe, active low |
| casl_n_o | output | 1 | Lower-byte column strobe, active low |
| cash_n_o | output | 1 | Upper-byte column strobe, active low |
| we_n_o | output | 1 | Write enable, active low, held high |
| addr_o | output | ROW_W | Row number in RAS_ONLY mode |
| addr_oe_o | output | 1 | Address bus drive enable |

## Verification
The bench lets the count run into saturation and beyond. A design that wrapped the counter, or let urgent lag the count, would show a small count or a low flag there.

It checks each strobe phase on the exact cycle it should begin and end. An off-by-one phase counter, or a row strobe that falls before the column strobes in the default mode, shows up as a wrong level on one of those cycles.

A grant is timed so that a refresh completes on the same edge as an interval. A design that lets one update win would lose or invent a refresh.

The row-only variant runs for more than 1024 refreshes, to catch a row counter that fails to wrap or skips rows.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETUP  = 2'd1,
    SQ_ACTIVE = 2'd2,
    SQ_PRECHG = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic ras_n;
    logic casl_n;
    logic cash_n;
    logic we_n;
    logic addr_oe;
  } strobe_t;

  localparam strobe_t STROBE_REST = '{ras_n: 1'b1, casl_n: 1'b1, cash_n: 1'b1,
                                      we_n: 1'b1, addr_oe: 1'b0};
endpackage

// File: rtl/rf_interval_timer.sv
module rf_interval_timer #(
  parameter int TICK_CYCLES = 3125
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/rf_pending_ctr.sv
module rf_pending_ctr #(
  parameter int MAX_PEND = 8,
  parameter int PEND_W   = $clog2(MAX_PEND + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              fin_i,
  output logic [PEND_W-1:0] pend_o,
  output logic              urgent_o
);
  localparam logic [PEND_W-1:0] FULL = PEND_W'(MAX_PEND);

  logic [PEND_W-1:0] pend_q, pend_d;
  logic              urgent_q;

  always_comb begin
    pend_d = pend_q;
    if (tick_i && !fin_i && pend_q != FULL) pend_d = pend_q + 1'b1;
    else if (fin_i && !tick_i && pend_q != '0) pend_d = pend_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= '0;
      urgent_q <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      urgent_q <= (pend_d == FULL);
    end
  end

  assign pend_o   = pend_q;
  assign urgent_o = urgent_q;

  // R3: count never exceeds its limit
  p_pend_bound_r3: assert property (@(posedge clk) disable iff (rst)
    pend_q <= FULL);

  // R3: an interval at the limit is dropped, the count holds
  p_sat_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !fin_i && pend_q == FULL) |=> pend_q == FULL);

  // R6: a completion alone removes exactly one entry
  p_fin_dec_r6: assert property (@(posedge clk) disable iff (rst)
    (fin_i && !tick_i && pend_q != '0) |=> pend_q == $past(pend_q) - 1'b1);

  // R7: completion and interval together cancel
  p_both_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (fin_i && tick_i) |=> $stable(pend_q));
endmodule

// File: rtl/rf_strobe_seq.sv
module rf_strobe_seq
  import refresh_pkg::*;
#(
  parameter int SETUP_CYC   = 2,
  parameter int RAS_LOW_CYC = 4,
  parameter int PRE_CYC     = 2,
  parameter bit RAS_ONLY    = 1'b0
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start_i,
  output logic    busy_o,
  output logic    finish_o,
  output strobe_t strobe_o
);
  localparam int M1   = (SETUP_CYC > RAS_LOW_CYC) ? SETUP_CYC : RAS_LOW_CYC;
  localparam int MAXC = (M1 > PRE_CYC) ? M1 : PRE_CYC;
  localparam int SW   = (MAXC > 1) ? $clog2(MAXC) : 1;

  seq_state_e    state_q, state_d;
  logic [SW-1:0] cnt_q, cnt_d;
  strobe_t       strobe_q, strobe_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    finish_o = 1'b0;
    unique case (state_q)
      SQ_IDLE: if (start_i) begin
        state_d = SQ_SETUP;
        cnt_d   = SW'(SETUP_CYC - 1);
      end
      SQ_SETUP: if (cnt_q == '0) begin
        state_d = SQ_ACTIVE;
        cnt_d   = SW'(RAS_LOW_CYC - 1);
      end else cnt_d = cnt_q - 1'b1;
      SQ_ACTIVE: if (cnt_q == '0) begin
        state_d = SQ_PRECHG;
        cnt_d   = SW'(PRE_CYC - 1);
      end else cnt_d = cnt_q - 1'b1;
      SQ_PRECHG: if (cnt_q == '0) begin
        state_d  = SQ_IDLE;
        finish_o = 1'b1;
      end else cnt_d = cnt_q - 1'b1;
      default: state_d = SQ_IDLE;
    endcase
  end

  generate
    if (RAS_ONLY) begin : g_row_only
      always_comb begin
        strobe_d = STROBE_REST;
        case (state_d)
          SQ_SETUP:  strobe_d.addr_oe = 1'b1;
          SQ_ACTIVE: begin
            strobe_d.addr_oe = 1'b1;
            strobe_d.ras_n   = 1'b0;
          end
          default: ;
        endcase
      end
    end else begin : g_cas_first
      always_comb begin
        strobe_d = STROBE_REST;
        case (state_d)
          SQ_SETUP: begin
            strobe_d.casl_n = 1'b0;
            strobe_d.cash_n = 1'b0;
          end
          SQ_ACTIVE: begin
            strobe_d.casl_n = 1'b0;
            strobe_d.cash_n = 1'b0;
            strobe_d.ras_n  = 1'b0;
          end
          default: ;
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SQ_IDLE;
      cnt_q    <= '0;
      strobe_q <= STROBE_REST;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      strobe_q <= strobe_d;
    end
  end

  assign busy_o   = (state_q != SQ_IDLE);
  assign strobe_o = strobe_q;

  generate
    if (RAS_ONLY) begin : g_chk_ro
      // R8: column strobes stay high while the row strobe is low
      p_ro_cas_high_r8: assert property (@(posedge clk) disable iff (rst)
        !strobe_q.ras_n |-> (strobe_q.casl_n && strobe_q.cash_n && strobe_q.addr_oe));
    end else begin : g_chk_cbr
      // R5: row strobe only falls with both column strobes already low
      p_cas_before_ras_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe_q.ras_n) |-> (!strobe_q.casl_n && !strobe_q.cash_n
                                   && !$past(strobe_q.casl_n) && !$past(strobe_q.cash_n)));
    end
  endgenerate

  // R10: write enable never asserted during refresh
  p_we_high_r10: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> strobe_q.we_n);
endmodule

// File: rtl/rf_row_ctr.sv
module rf_row_ctr #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  output logic [ROW_W-1:0] row_o
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (rst) row_q <= '0;
    else if (inc_i) row_q <= row_q + 1'b1;
  end

  assign row_o = row_q;

  // R9: each completion advances the row by one, wrapping at the top
  p_row_step_r9: assert property (@(posedge clk) disable iff (rst)
    inc_i |=> row_q == $past(row_q) + 1'b1);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_pkg::*;
#(
  parameter int TICK_CYCLES = 3125,
  parameter int MAX_PEND    = 8,
  parameter int SETUP_CYC   = 2,
  parameter int RAS_LOW_CYC = 4,
  parameter int PRE_CYC     = 2,
  parameter int ROW_W       = 10,
  parameter bit RAS_ONLY    = 1'b0
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            gnt_i,
  output logic                            req_o,
  output logic                            urgent_o,
  output logic [$clog2(MAX_PEND+1)-1:0]   pend_o,
  output logic                            busy_o,
  output logic                            done_o,
  output logic                            ras_n_o,
  output logic                            casl_n_o,
  output logic                            cash_n_o,
  output logic                            we_n_o,
  output logic [ROW_W-1:0]                addr_o,
  output logic                            addr_oe_o
);
  localparam int PEND_W = $clog2(MAX_PEND + 1);

  logic              tick, finish, start, busy, done_q;
  logic [PEND_W-1:0] pend;
  logic [ROW_W-1:0]  row;
  strobe_t           strobe;

  rf_interval_timer #(.TICK_CYCLES(TICK_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .tick_o(tick));

  rf_pending_ctr #(.MAX_PEND(MAX_PEND), .PEND_W(PEND_W)) u_pend (
    .clk(clk), .rst(rst), .tick_i(tick), .fin_i(finish),
    .pend_o(pend), .urgent_o(urgent_o));

  assign req_o = (pend != '0) && !busy;
  assign start = req_o && gnt_i;

  rf_strobe_seq #(.SETUP_CYC(SETUP_CYC), .RAS_LOW_CYC(RAS_LOW_CYC),
                  .PRE_CYC(PRE_CYC), .RAS_ONLY(RAS_ONLY)) u_seq (
    .clk(clk), .rst(rst), .start_i(start), .busy_o(busy),
    .finish_o(finish), .strobe_o(strobe));

  generate
    if (RAS_ONLY) begin : g_rows
      rf_row_ctr #(.ROW_W(ROW_W)) u_row (
        .clk(clk), .rst(rst), .inc_i(finish), .row_o(row));
    end else begin : g_no_rows
      assign row = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else done_q <= finish;
  end

  assign pend_o    = pend;
  assign busy_o    = busy;
  assign done_o    = done_q;
  assign ras_n_o   = strobe.ras_n;
  assign casl_n_o  = strobe.casl_n;
  assign cash_n_o  = strobe.cash_n;
  assign we_n_o    = strobe.we_n;
  assign addr_oe_o = strobe.addr_oe;
  assign addr_o    = row & {ROW_W{strobe.addr_oe}};

  // R4: a grant without a request starts no cycle
  p_grant_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (gnt_i && !req_o && !busy) |=> !busy);

  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

// File: tb/tb_refresh_sched.sv
`timescale 1ns/1ps
module tb_refresh_sched;
  localparam int TICK = 20;
  localparam int MAXP = 8;
  localparam int PW   = $clog2(MAXP + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gnt = 1'b0;
  always #2.5 clk = ~clk;

  logic          req, urg, busy, done, ras, casl, cash, we, oe;
  logic [PW-1:0] pend;
  logic [9:0]    addr;
  logic          r_req, r_urg, r_busy, r_done, r_ras, r_casl, r_cash, r_we, r_oe;
  logic [PW-1:0] r_pend;
  logic [9:0]    r_addr;

  refresh_sched #(.TICK_CYCLES(TICK), .MAX_PEND(MAXP), .SETUP_CYC(2),
                  .RAS_LOW_CYC(3), .PRE_CYC(2), .ROW_W(10), .RAS_ONLY(1'b0)) dut (
    .clk(clk), .rst(rst), .gnt_i(gnt), .req_o(req), .urgent_o(urg), .pend_o(pend),
    .busy_o(busy), .done_o(done), .ras_n_o(ras), .casl_n_o(casl), .cash_n_o(cash),
    .we_n_o(we), .addr_o(addr), .addr_oe_o(oe));

  refresh_sched #(.TICK_CYCLES(TICK), .MAX_PEND(MAXP), .SETUP_CYC(2),
                  .RAS_LOW_CYC(3), .PRE_CYC(2), .ROW_W(10), .RAS_ONLY(1'b1)) dut_ro (
    .clk(clk), .rst(rst), .gnt_i(gnt), .req_o(r_req), .urgent_o(r_urg), .pend_o(r_pend),
    .busy_o(r_busy), .done_o(r_done), .ras_n_o(r_ras), .casl_n_o(r_casl), .cash_n_o(r_cash),
    .we_n_o(r_we), .addr_o(r_addr), .addr_oe_o(r_oe));

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // {cycles to wait, expected pending, expected urgent, expected request}
  localparam int VEC [7][4] = '{
    '{19, 0, 0, 0}, '{1, 1, 0, 1}, '{19, 1, 0, 1}, '{1, 2, 0, 1},
    '{60, 5, 0, 1}, '{60, 8, 1, 1}, '{40, 8, 1, 1}};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    finish_run();
  end

  initial begin
    step(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 pend", int'(pend), 0);
    chk("R1 req/urgent/busy/done", int'({req, urg, busy, done}), 0);
    chk("R1 strobes", int'({ras, casl, cash, we}), 4'hF);
    chk("R1 addr oe", int'({r_oe, r_addr}), 0);

    // table walk: R2 intervals, R3 saturation and urgent, R4 request
    for (int i = 0; i < 7; i++) begin
      step(VEC[i][0]);
      chk($sformatf("R2/R3 pend vec%0d", i), int'(pend), VEC[i][1]);
      chk($sformatf("R3 urgent vec%0d", i), int'(urg), VEC[i][2]);
      chk($sformatf("R4 req vec%0d", i), int'(req), VEC[i][3]);
    end

    // first refresh, grant taken at edge 201
    gnt = 1'b1;
    step(1);
    gnt = 1'b0;
    chk("R5 setup cas low", int'({casl, cash}), 0);
    chk("R5 setup ras high", int'(ras), 1);
    chk("R5 addr not driven", int'(oe), 0);
    chk("R4 req low while busy", int'({req, busy}), 2'b01);
    chk("R8 ro setup cas high", int'({r_casl, r_cash, r_ras}), 3'b111);
    chk("R8 ro oe", int'(r_oe), 1);
    chk("R9 first row", int'(r_addr), 0);
    step(1);
    chk("R5 setup length", int'(ras), 1);
    step(1);
    chk("R5 ras low cas low", int'({ras, casl, cash}), 0);
    chk("R8 ro ras low cas high", int'({r_ras, r_casl, r_cash, r_oe}), 4'b0111);
    step(2);
    chk("R5 ras low length", int'(ras), 0);
    step(1);
    chk("R5 precharge all high", int'({ras, casl, cash, we}), 4'hF);
    chk("R8 ro oe drops", int'(r_oe), 0);
    step(1);
    chk("R6 no done in precharge", int'({busy, done}), 2'b10);
    step(1);
    chk("R6 done pulse", int'(done), 1);
    chk("R6 pend decremented", int'(pend), 7);
    chk("R3 urgent cleared", int'(urg), 0);
    chk("R4 req again", int'({req, busy}), 2'b10);
    step(1);
    chk("R6 done one cycle", int'(done), 0);

    // second refresh timed to complete on the interval edge 220
    step(3);
    gnt = 1'b1;
    step(1);
    gnt = 1'b0;
    chk("R9 second row", int'({r_oe, r_addr}), {1'b1, 10'd1});
    step(7);
    chk("R7 tick and done cancel", int'(pend), 7);
    chk("R6 done at collision", int'(done), 1);

    // fresh reset, grant held high, long run for row wrap
    rst = 1'b1;
    gnt = 1'b1;
    step(3);
    rst = 1'b0;
    step(10);
    chk("R4 grant ignored without request", int'({busy, ras, casl}), 3'b011);
    chk("R4 ro grant ignored", int'({r_busy, r_oe}), 0);
    begin
      int k = 0;
      int mism = 0;
      int we_bad = 0;
      int row_at_wrap = -1;
      bit prev = 1'b0;
      while (k < 1025) begin
        step(1);
        if (!we || !r_we) we_bad++;
        if (r_oe && !prev) begin
          if (int'(r_addr) != (k % 1024)) mism++;
          if (k == 1024) row_at_wrap = int'(r_addr);
          k++;
        end
        prev = r_oe;
      end
      chk("R9 row sequence mismatches", mism, 0);
      chk("R9 row wraps to 0", row_at_wrap, 0);
      chk("R10 write enable high", we_bad, 0);
    end
    gnt = 1'b0;
    finish_run();
  end
endmodule